// File: doc/BRIEF.md
# Timer Clock Routing and Control

This block sits in front of three timer counters and produces, for each of them, a one-cycle count-enable strobe in the system clock domain. A channel counts either from one of five internal prescaled tick sources or from one of three shared external lines. It can count on the falling edge of an external line instead of the rising one. It can also be gated by the level of an external line. The counters themselves live outside; they consume the strobes and return their TIOA waveform outputs, which can be routed back as external lines to chain channels.

Each shared external line is picked from a dedicated input pin, from the TIOA output of one of the two other channels, or tied low. Every pin and TIOA input passes through a two-flop synchronizer before edge detection. The block also holds the per-channel clock-on state, set and cleared by command pulses. It turns per-channel software trigger pulses and a block-wide synchronous trigger into per-channel trigger strobes. Divide ratios are parameters; a ratio of 0 replaces that prescaler with a slow-tick input.

Top module: `tmr_clk_route`

## Requirements
- R1: After reset, `clk_on_o`, `cnt_en_o` and `trig_o` are all 0.
- R2: A `cmd_en_i[c]` pulse sets `clk_on_o[c]` on the next clock edge, a `cmd_dis_i[c]` pulse clears it, and when both arrive in the same cycle the channel ends up off.
- R3: Clock-select codes 0 to 4 (field `clk_sel_i[3c+2:3c]`) pick internal tick sources 1 to 5. For a non-zero divisor the strobe repeats every DIVn cycles while the channel is on.
- R4: An internal source whose divisor parameter is 0 follows `slow_tick_i`: each one-cycle slow-tick pulse gives one strobe on the following cycle.
- R5: Clock-select codes 5, 6, 7 pick external lines 0, 1, 2. A rising edge on the selected source input gives a strobe exactly three clock edges after the input changes (two synchronizer stages, one edge register).
- R6: With `clk_inv_i[c]` = 1 an external source counts on its falling edge instead of its rising edge. For internal sources the bit has no effect.
- R7: Line k takes its source from field `xsel_i[2k+1:2k]`: 0 = pin `ext_pin_i[k]`, 1 = tied low, 2 = TIOA of the lower-numbered other channel, 3 = TIOA of the higher-numbered other channel.
- R8: Gate field `gate_sel_i[2c+1:2c]` = 0 leaves counting ungated. Codes 1 to 3 allow a strobe only while external line 0, 1 or 2 is high.
- R9: A channel whose clock is off produces no strobes.
- R10: A `cmd_trg_i[c]` pulse gives a one-cycle `trig_o[c]` on the next clock edge.
- R11: A `sync_i` pulse raises all three bits of `trig_o` together on the next clock edge.
- R12: Each qualifying external edge gives exactly one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle slow tick, used by internal sources with divisor 0 |
| ext_pin_i | input | 3 | Dedicated external clock pins, one per shared line |
| tioa_i | input | 3 | TIOA outputs returned from the three counters |
| xsel_i | input | 6 | Source code for each shared line, two bits per line |
| clk_sel_i | input | 9 | Clock-select code, three bits per channel |
| clk_inv_i | input | 3 | Falling-edge select per channel |
| gate_sel_i | input | 6 | Gate code, two bits per channel |
| cmd_en_i | input | 3 | Clock-on command pulse per channel |
| cmd_dis_i | input | 3 | Clock-off command pulse per channel |
| cmd_trg_i | input | 3 | Software trigger pulse per channel |
| sync_i | input | 1 | Block-wide trigger pulse |
| cnt_en_o | output | 3 | Count-enable strobe per channel |
| trig_o | output | 3 | Trigger strobe per channel |
| clk_on_o | output | 3 | Current clock-on state per channel |

## Verification
The single-cycle property for external strobes assumes that the clock-select code and invert bit stay put across the edge being counted. The other properties expect that no command pulse arrives while the internal reset is still held. The bench changes routing, select and invert settings only while a channel is off or during flush cycles whose strobes it ignores. It waits four cycles after reset before the first command. The routing sweep covers every line, every source code and both edge polarities. It raises decoy inputs first, so a strobe from the wrong source shows up before the real edge.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned NCH  = 3;
  localparam int unsigned NINT = 5;
  localparam int unsigned NXL  = 3;
  localparam int unsigned CSW  = 3;
  localparam int unsigned GSW  = 2;
  localparam int unsigned XSW  = 2;

  typedef enum logic [1:0] {
    XSRC_PIN = 2'd0,
    XSRC_OFF = 2'd1,
    XSRC_LO  = 2'd2,
    XSRC_HI  = 2'd3
  } xsrc_e;

  // lower-numbered channel other than k
  function automatic int unsigned peer_lo(input int unsigned k);
    return (k == 0) ? 1 : 0;
  endfunction

  // higher-numbered channel other than k
  function automatic int unsigned peer_hi(input int unsigned k);
    return (k == 2) ? 1 : 2;
  endfunction
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st1_q;
  logic [W-1:0] st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
    end
  end

  assign q_o = st2_q;
endmodule

// File: rtl/tcr_prescaler.sv
module tcr_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV < 2) ? 1 : $clog2(DIV);

  generate
    if (DIV == 0) begin : g_slow
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tick_o = slow_tick_i;
    end else begin : g_div
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;
      logic [W-1:0] cnt_d;
      logic         wrap;
      logic         unused_slow;

      assign unused_slow = slow_tick_i;
      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (wrap) cnt_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = wrap;
    end
  endgenerate
endmodule

// File: rtl/tcr_xroute.sv
module tcr_xroute
  import tcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NXL-1:0]     pin_s_i,
  input  logic [NCH-1:0]     tioa_s_i,
  input  logic [NXL*XSW-1:0] xsel_i,
  output logic [NXL-1:0]     lvl_o,
  output logic [NXL-1:0]     rise_o,
  output logic [NXL-1:0]     fall_o
);
  logic [NXL-1:0] lvl_q;

  generate
    for (genvar k = 0; k < NXL; k++) begin : g_line
      localparam int unsigned LO = peer_lo(k);
      localparam int unsigned HI = peer_hi(k);
      xsrc_e src;
      assign src = xsrc_e'(xsel_i[XSW*k +: XSW]);

      always_comb begin
        unique case (src)
          XSRC_PIN: lvl_o[k] = pin_s_i[k];
          XSRC_OFF: lvl_o[k] = 1'b0;
          XSRC_LO:  lvl_o[k] = tioa_s_i[LO];
          default:  lvl_o[k] = tioa_s_i[HI];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~lvl_q;
  assign fall_o = ~lvl_o & lvl_q;
endmodule

// File: rtl/tcr_chan.sv
module tcr_chan
  import tcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NINT-1:0] tick_i,
  input  logic [NXL-1:0]  lvl_i,
  input  logic [NXL-1:0]  rise_i,
  input  logic [NXL-1:0]  fall_i,
  input  logic [CSW-1:0]  sel_i,
  input  logic            inv_i,
  input  logic [GSW-1:0]  gate_i,
  input  logic            en_i,
  input  logic            dis_i,
  input  logic            trg_i,
  input  logic            sync_i,
  output logic            cnt_en_o,
  output logic            trig_o,
  output logic            clk_on_o
);
  logic on_q, on_d;
  logic cnt_q, cnt_d;
  logic trg_q, trg_d;
  logic evt;
  logic gate_ok;
  logic [NXL-1:0] xedge;

  assign xedge = inv_i ? fall_i : rise_i;

  always_comb begin
    unique case (sel_i)
      3'd0:    evt = tick_i[0];
      3'd1:    evt = tick_i[1];
      3'd2:    evt = tick_i[2];
      3'd3:    evt = tick_i[3];
      3'd4:    evt = tick_i[4];
      3'd5:    evt = xedge[0];
      3'd6:    evt = xedge[1];
      default: evt = xedge[2];
    endcase
  end

  always_comb begin
    unique case (gate_i)
      2'd0:    gate_ok = 1'b1;
      2'd1:    gate_ok = lvl_i[0];
      2'd2:    gate_ok = lvl_i[1];
      default: gate_ok = lvl_i[2];
    endcase
  end

  always_comb begin
    on_d = on_q;
    if (en_i)  on_d = 1'b1;
    if (dis_i) on_d = 1'b0;
    cnt_d = on_q & evt & gate_ok;
    trg_d = trg_i | sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
      trg_q <= trg_d;
    end
  end

  assign cnt_en_o = cnt_q;
  assign trig_o   = trg_q;
  assign clk_on_o = on_q;
endmodule

// File: rtl/tmr_clk_route.sv
module tmr_clk_route
  import tcr_pkg::*;
#(
  parameter int unsigned DIV1 = 2,
  parameter int unsigned DIV2 = 8,
  parameter int unsigned DIV3 = 32,
  parameter int unsigned DIV4 = 128,
  parameter int unsigned DIV5 = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_tick_i,
  input  logic [NXL-1:0]     ext_pin_i,
  input  logic [NCH-1:0]     tioa_i,
  input  logic [NXL*XSW-1:0] xsel_i,
  input  logic [NCH*CSW-1:0] clk_sel_i,
  input  logic [NCH-1:0]     clk_inv_i,
  input  logic [NCH*GSW-1:0] gate_sel_i,
  input  logic [NCH-1:0]     cmd_en_i,
  input  logic [NCH-1:0]     cmd_dis_i,
  input  logic [NCH-1:0]     cmd_trg_i,
  input  logic               sync_i,
  output logic [NCH-1:0]     cnt_en_o,
  output logic [NCH-1:0]     trig_o,
  output logic [NCH-1:0]     clk_on_o
);
  localparam int unsigned DIVS [NINT] = '{DIV1, DIV2, DIV3, DIV4, DIV5};
  localparam int unsigned SYW = NXL + NCH;

  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic [SYW-1:0]  raw_in;
  logic [SYW-1:0]  syn_in;
  logic [NINT-1:0] tick;
  logic [NXL-1:0]  lvl, rise, fall;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw_in = {tioa_i, ext_pin_i};

  tcr_sync #(.W(SYW)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  generate
    for (genvar i = 0; i < NINT; i++) begin : g_pre
      tcr_prescaler #(.DIV(DIVS[i])) u_pre (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .slow_tick_i (slow_tick_i),
        .tick_o      (tick[i])
      );
    end
  endgenerate

  tcr_xroute u_xroute (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_s_i  (syn_in[NXL-1:0]),
    .tioa_s_i (syn_in[SYW-1:NXL]),
    .xsel_i   (xsel_i),
    .lvl_o    (lvl),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      tcr_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .tick_i   (tick),
        .lvl_i    (lvl),
        .rise_i   (rise),
        .fall_i   (fall),
        .sel_i    (clk_sel_i[CSW*c +: CSW]),
        .inv_i    (clk_inv_i[c]),
        .gate_i   (gate_sel_i[GSW*c +: GSW]),
        .en_i     (cmd_en_i[c]),
        .dis_i    (cmd_dis_i[c]),
        .trg_i    (cmd_trg_i[c]),
        .sync_i   (sync_i),
        .cnt_en_o (cnt_en_o[c]),
        .trig_o   (trig_o[c]),
        .clk_on_o (clk_on_o[c])
      );
    end
  endgenerate
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker
  import tcr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NCH*CSW-1:0] clk_sel_i,
  input logic [NCH-1:0]     clk_inv_i,
  input logic [NCH-1:0]     cmd_en_i,
  input logic [NCH-1:0]     cmd_dis_i,
  input logic [NCH-1:0]     cmd_trg_i,
  input logic               sync_i,
  input logic [NCH-1:0]     cnt_en_o,
  input logic [NCH-1:0]     trig_o,
  input logic [NCH-1:0]     clk_on_o
);
  AST_SYNC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (trig_o == {NCH{1'b1}})); // R11

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en_i[c] && cmd_dis_i[c]) |=> !clk_on_o[c]); // R2
      AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en_i[c] && !cmd_dis_i[c]) |=> clk_on_o[c]); // R2
      AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_o[c] |-> $past(clk_on_o[c])); // R9
      AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o[c] |-> $past(cmd_trg_i[c] || sync_i)); // R10
      AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_o[c] && (clk_sel_i[CSW*c +: CSW] >= 3'd5)
         && $stable(clk_sel_i[CSW*c +: CSW]) && $stable(clk_inv_i[c]))
        |=> !cnt_en_o[c]); // R12
    end
  endgenerate
endmodule

bind tmr_clk_route tcr_checker u_tcr_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clk_sel_i (clk_sel_i),
  .clk_inv_i (clk_inv_i),
  .cmd_en_i  (cmd_en_i),
  .cmd_dis_i (cmd_dis_i),
  .cmd_trg_i (cmd_trg_i),
  .sync_i    (sync_i),
  .cnt_en_o  (cnt_en_o),
  .trig_o    (trig_o),
  .clk_on_o  (clk_on_o)
);

// File: tb/tmr_clk_route_bench.sv
`timescale 1ns/1ps
module tmr_clk_route_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       slow_tick_i;
  logic [2:0] ext_pin_i, tioa_i;
  logic [5:0] xsel_i;
  logic [8:0] clk_sel_i;
  logic [2:0] clk_inv_i;
  logic [5:0] gate_sel_i;
  logic [2:0] cmd_en_i, cmd_dis_i, cmd_trg_i;
  logic       sync_i;
  logic [2:0] cnt_en_o, trig_o, clk_on_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int exp_div [4] = '{1, 2, 3, 4};

  always #4 clk = ~clk;

  tmr_clk_route #(.DIV1(1), .DIV2(2), .DIV3(3), .DIV4(4), .DIV5(0)) u_tmr_clk_route (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick_i), .ext_pin_i(ext_pin_i),
    .tioa_i(tioa_i), .xsel_i(xsel_i), .clk_sel_i(clk_sel_i), .clk_inv_i(clk_inv_i),
    .gate_sel_i(gate_sel_i), .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i),
    .cmd_trg_i(cmd_trg_i), .sync_i(sync_i), .cnt_en_o(cnt_en_o), .trig_o(trig_o),
    .clk_on_o(clk_on_o)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_on(input int ch, input bit on);
    if (on) cmd_en_i[ch] = 1'b1; else cmd_dis_i[ch] = 1'b1;
    cyc();
    cmd_en_i = '0;
    cmd_dis_i = '0;
  endtask

  // cycles between two consecutive strobes of a channel
  task automatic period(input int ch, output int per);
    int n;
    per = -1;
    for (int w = 0; w < 20; w++) begin
      cyc();
      if (cnt_en_o[ch]) break;
    end
    n = 0;
    for (int w = 0; w < 20; w++) begin
      cyc();
      n++;
      if (cnt_en_o[ch]) begin
        per = n;
        break;
      end
    end
  endtask

  task automatic count_strobes(input int ch, input int len, output int cnt);
    cnt = 0;
    for (int w = 0; w < len; w++) begin
      cyc();
      if (cnt_en_o[ch]) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int per, cnt;
    rst_n = 1'b0; slow_tick_i = 1'b0; ext_pin_i = '0; tioa_i = '0;
    xsel_i = '0; clk_sel_i = '0; clk_inv_i = '0; gate_sel_i = '0;
    cmd_en_i = '0; cmd_dis_i = '0; cmd_trg_i = '0; sync_i = 1'b0;
    repeat (4) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1
    chk(clk_on_o == 0 && cnt_en_o == 0 && trig_o == 0, "R1 reset outputs",
        {clk_on_o, cnt_en_o, trig_o}, 0);

    // R2 enable, disable, both together
    set_on(0, 1'b1);
    chk(clk_on_o[0] == 1'b1, "R2 enable", clk_on_o[0], 1);
    cmd_en_i[0] = 1'b1; cmd_dis_i[0] = 1'b1; cyc(); cmd_en_i = '0; cmd_dis_i = '0;
    chk(clk_on_o[0] == 1'b0, "R2 disable wins from on", clk_on_o[0], 0);
    cmd_en_i[1] = 1'b1; cmd_dis_i[1] = 1'b1; cyc(); cmd_en_i = '0; cmd_dis_i = '0;
    chk(clk_on_o[1] == 1'b0, "R2 disable wins from off", clk_on_o[1], 0);
    set_on(2, 1'b1);
    set_on(2, 1'b0);
    chk(clk_on_o[2] == 1'b0, "R2 disable", clk_on_o[2], 0);

    // R3 internal tick periods, every channel and code 0..3
    for (int ch = 0; ch < 3; ch++) begin
      for (int code = 0; code < 4; code++) begin
        clk_sel_i[3*ch +: 3] = 3'(code);
        set_on(ch, 1'b1);
        period(ch, per);
        chk(per == exp_div[code], $sformatf("R3 ch%0d code%0d period", ch, code), per, exp_div[code]);
        set_on(ch, 1'b0);
      end
    end

    // R6 invert has no effect on an internal source
    clk_sel_i[2:0] = 3'd2; clk_inv_i[0] = 1'b1;
    set_on(0, 1'b1);
    period(0, per);
    chk(per == 3, "R6 invert ignored on internal", per, 3);
    set_on(0, 1'b0);
    clk_inv_i = '0;

    // R4 divisor 0 follows slow tick
    clk_sel_i[5:3] = 3'd4;
    set_on(1, 1'b1);
    count_strobes(1, 6, cnt);
    chk(cnt == 0, "R4 no slow tick no strobe", cnt, 0);
    slow_tick_i = 1'b1; cyc(); slow_tick_i = 1'b0;
    chk(cnt_en_o[1] == 1'b1, "R4 strobe after slow tick", cnt_en_o[1], 1);
    cyc();
    chk(cnt_en_o[1] == 1'b0, "R4 strobe one cycle", cnt_en_o[1], 0);
    set_on(1, 1'b0);

    // R5/R6/R7/R12 every line, every source code, both polarities (channel 0)
    for (int inv = 0; inv < 2; inv++) begin
      for (int k = 0; k < 3; k++) begin
        for (int code = 0; code < 4; code++) begin
          int lo, hi;
          logic [5:0] src_vec, all_vec;
          logic [9:0] mask, exp_mask;
          lo = (k == 0) ? 1 : 0;
          hi = (k == 2) ? 1 : 2;
          case (code)
            0: src_vec = 6'(1) << k;
            2: src_vec = 6'(1) << (3 + lo);
            3: src_vec = 6'(1) << (3 + hi);
            default: src_vec = 6'd0;
          endcase
          all_vec = 6'h3f;
          set_on(0, 1'b0);
          xsel_i = '0;
          xsel_i[2*k +: 2] = 2'(code);
          clk_sel_i[2:0] = 3'(5 + k);
          clk_inv_i[0] = inv[0];
          {tioa_i, ext_pin_i} = inv ? all_vec : 6'd0;
          repeat (5) cyc();
          set_on(0, 1'b1);
          repeat (2) cyc();
          // decoys change first
          {tioa_i, ext_pin_i} = inv ? (all_vec & src_vec) : (all_vec & ~src_vec);
          mask = '0;
          for (int w = 0; w < 4; w++) begin
            cyc();
            mask[w] = cnt_en_o[0];
          end
          {tioa_i, ext_pin_i} = inv ? 6'd0 : all_vec;
          for (int w = 4; w < 10; w++) begin
            cyc();
            mask[w] = cnt_en_o[0];
          end
          exp_mask = (code == 1) ? 10'd0 : 10'b0001000000;
          chk(mask == exp_mask,
              $sformatf("R5/R7/R12 line%0d code%0d inv%0d (R6) strobe mask", k, code, inv),
              mask, exp_mask);
        end
      end
    end
    set_on(0, 1'b0);
    {tioa_i, ext_pin_i} = '0; xsel_i = '0; clk_inv_i = '0;

    // R8 gating, channel 1 on internal divisor 1
    clk_sel_i[5:3] = 3'd0;
    set_on(1, 1'b1);
    gate_sel_i[3:2] = 2'd0;
    repeat (4) cyc();
    count_strobes(1, 8, cnt);
    chk(cnt == 8, "R8 ungated", cnt, 8);
    for (int g = 1; g < 4; g++) begin
      gate_sel_i[3:2] = 2'(g);
      ext_pin_i = '0;
      repeat (4) cyc();
      count_strobes(1, 8, cnt);
      chk(cnt == 0, $sformatf("R8 gate%0d line low", g), cnt, 0);
      ext_pin_i = 3'(1) << (g - 1);
      repeat (4) cyc();
      count_strobes(1, 8, cnt);
      chk(cnt == 8, $sformatf("R8 gate%0d line high", g), cnt, 8);
    end
    set_on(1, 1'b0);
    gate_sel_i = '0; ext_pin_i = '0;

    // R9 channel off stays silent
    clk_sel_i[8:6] = 3'd0;
    repeat (2) cyc();
    count_strobes(2, 8, cnt);
    chk(cnt == 0, "R9 off channel silent", cnt, 0);

    // R10 software trigger
    cmd_trg_i[1] = 1'b1; cyc(); cmd_trg_i = '0;
    chk(trig_o == 3'b010, "R10 trigger ch1", trig_o, 3'b010);
    cyc();
    chk(trig_o == 3'b000, "R10 trigger one cycle", trig_o, 0);

    // R11 block-wide trigger
    sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk(trig_o == 3'b111, "R11 sync all channels", trig_o, 3'b111);
    cyc();
    chk(trig_o == 3'b000, "R11 sync one cycle", trig_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule